// File: doc/BRIEF.md
# AES Decryption Round Tail with Column-Signature Fault Check

This block performs the second half of one AES decryption round. It XORs a 128-bit state with a 128-bit round key, then applies the inverse column mix to the result. Alongside the datapath it runs a concurrent fault check. For every column it builds an 8-bit signature that stays zero while the round is computed correctly. It folds each signature into four flags and raises a single error bit whenever any flag is set. A mode input drops the inverse column mix so that the same unit serves the final decryption round. The flag equations are the same in both modes.

The check relies on one property of the inverse mix coefficients 0x0E, 0x0B, 0x0D and 0x09. Their XOR is 1, so the XOR of a column's four output bytes equals the XOR of its four key-mixed input bytes. The same equality holds trivially when the mix is bypassed. A fault mask input is XORed onto the computed state just before the output register. This lets a testbench inject errors that the checker must then see.

The control is a two-state machine. It sits in IDLE and moves to VALID on any cycle where `in_valid` is sampled high. It returns to IDLE on any cycle where `in_valid` is sampled low. A VALID-to-VALID self loop carries back-to-back inputs. VALID is the only state in which output data and flags are non-zero.

Top module: `aes_dec_ark_imc_chk`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_state`, `err_flags` and `err_any` are all zero.
- R2: An input sampled with `in_valid` high gives `out_valid` high on the following rising edge. Otherwise `out_valid` is low in that cycle, and `out_state` and `err_flags` are zero.
- R3: Byte b of a 128-bit state or key occupies bits [8b+7:8b]. Byte b sits in column b/4 and row b%4.
- R4: With `last_round` low and no fault, `out_state` equals the inverse column mix of (`in_state` XOR `round_key`). Output row r of each column is the XOR over input rows j of coef[(j-r) mod 4] times byte j, in GF(2^8) reduced by 0x11B, with coef = {0x0E, 0x0B, 0x0D, 0x09}.
- R5: With `last_round` high and no fault, `out_state` equals `in_state` XOR `round_key`.
- R6: With `fault_mask` zero, all flags and `err_any` are zero in both modes.
- R7: Column c has a signature equal to the XOR of its four output bytes, four input-state bytes and four key bytes. Flag index 4c+i (i = 0..3) is signature bit i XOR signature bit i+4.
- R8: `out_state` carries the computed state XOR `fault_mask`. The flags are derived from that faulty output.
- R9: Any single set bit in `fault_mask` raises `err_any`. It sets exactly one flag: index 4*(b/4) + (k%4) for bit k of byte b.
- R10: `err_any` is the OR of all 16 flags.
- R11: Two mask bits in one column produce no flag when they cancel in the fold. This happens either when they share a bit position in different rows, or when their bit positions differ by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs on this cycle are to be processed |
| last_round | input | 1 | High: skip the inverse column mix |
| in_state | input | 128 | State entering key addition |
| round_key | input | 128 | Round key for this round |
| fault_mask | input | 128 | Error pattern XORed onto the computed state |
| out_valid | output | 1 | Output state and flags are valid |
| out_state | output | 128 | Round result (with injected faults) |
| err_flags | output | 16 | Four fold flags per column, index 4c+i |
| err_any | output | 1 | OR of all flags |

## Verification
The bench builds the block with the default 128-bit state, which gives four columns and sixteen flags. With that width, the single-bit fault sweep walks all 128 mask positions in both round modes. Every flag index is hit from both of the byte halves that fold into it. The default width also brings within reach the cancelling mask pairs of R11 and known inverse-mix column vectors for the byte layout.

// File: rtl/aes_dec_chk_pkg.sv
package aes_dec_chk_pkg;

    localparam int BYTE_W   = 8;
    localparam int COL_ROWS = 4;
    localparam int COL_W    = BYTE_W * COL_ROWS;
    localparam int HALF_W   = BYTE_W / 2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } chk_state_e;

    // multiply by x in GF(2^8), reduction polynomial 0x11B
    function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? 8'h1B : 8'h00);
    endfunction

    // sel 0..3 picks 0x0E, 0x0B, 0x0D, 0x09
    function automatic logic [BYTE_W-1:0] gf_inv_coef_mul(input logic [1:0] sel,
                                                          input logic [BYTE_W-1:0] a);
        logic [BYTE_W-1:0] x2, x4, x8, res;
        x2 = gf_dbl(a);
        x4 = gf_dbl(x2);
        x8 = gf_dbl(x4);
        unique case (sel)
            2'd0:    res = x8 ^ x4 ^ x2;
            2'd1:    res = x8 ^ x2 ^ a;
            2'd2:    res = x8 ^ x4 ^ a;
            default: res = x8 ^ a;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/aes_inv_mix_col.sv
module aes_inv_mix_col
    import aes_dec_chk_pkg::*;
(
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);

    for (genvar r = 0; r < COL_ROWS; r++) begin : g_row
        logic [BYTE_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int j = 0; j < COL_ROWS; j++) begin
                acc ^= gf_inv_coef_mul(2'(j - r), col_in[j*BYTE_W +: BYTE_W]);
            end
        end
        assign col_out[r*BYTE_W +: BYTE_W] = acc;
    end

endmodule

// File: rtl/aes_col_sig.sv
module aes_col_sig
    import aes_dec_chk_pkg::*;
(
    input  logic [COL_W-1:0]  col_pre,
    input  logic [COL_W-1:0]  col_key,
    input  logic [COL_W-1:0]  col_out,
    output logic [HALF_W-1:0] flags
);

    logic [BYTE_W-1:0] sig;

    always_comb begin
        sig = '0;
        for (int j = 0; j < COL_ROWS; j++) begin
            sig ^= col_pre[j*BYTE_W +: BYTE_W]
                 ^ col_key[j*BYTE_W +: BYTE_W]
                 ^ col_out[j*BYTE_W +: BYTE_W];
        end
    end

    // fold low nibble against high nibble (R7)
    assign flags = sig[HALF_W-1:0] ^ sig[BYTE_W-1:HALF_W];

endmodule

// File: rtl/aes_dec_ark_imc_chk.sv
module aes_dec_ark_imc_chk
    import aes_dec_chk_pkg::*;
#(
    parameter int STATE_W = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        last_round,
    input  logic [STATE_W-1:0]          in_state,
    input  logic [STATE_W-1:0]          round_key,
    input  logic [STATE_W-1:0]          fault_mask,
    output logic                        out_valid,
    output logic [STATE_W-1:0]          out_state,
    output logic [STATE_W/BYTE_W-1:0]   err_flags,
    output logic                        err_any
);

    localparam int NCOL  = STATE_W / COL_W;
    localparam int NFLAG = NCOL * HALF_W;

    logic [STATE_W-1:0] ark;
    logic [STATE_W-1:0] mixed;
    logic [STATE_W-1:0] rnd;
    logic [STATE_W-1:0] faulty;
    logic [NFLAG-1:0]   flags_d;

    assign ark = in_state ^ round_key;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        aes_inv_mix_col u_mix (
            .col_in  (ark[c*COL_W +: COL_W]),
            .col_out (mixed[c*COL_W +: COL_W])
        );
        aes_col_sig u_sig (
            .col_pre (in_state[c*COL_W +: COL_W]),
            .col_key (round_key[c*COL_W +: COL_W]),
            .col_out (faulty[c*COL_W +: COL_W]),
            .flags   (flags_d[c*HALF_W +: HALF_W])
        );
    end

    assign rnd    = last_round ? ark : mixed;
    assign faulty = rnd ^ fault_mask;

    // ---------------- state machine ----------------
    chk_state_e st_q, st_d;

    always_comb begin
        st_d = in_valid ? ST_VALID : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- output registers ----------------
    logic [STATE_W-1:0] state_q;
    logic [NFLAG-1:0]   flags_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            flags_q <= '0;
        end else begin
            unique case (st_d)
                ST_VALID: begin
                    state_q <= faulty;
                    flags_q <= flags_d;
                end
                ST_IDLE: begin
                    state_q <= '0;
                    flags_q <= '0;
                end
                default: begin
                    state_q <= '0;
                    flags_q <= '0;
                end
            endcase
        end
    end

    assign out_valid = (st_q == ST_VALID);
    assign out_state = state_q;
    assign err_flags = flags_q;
    assign err_any   = |flags_q;

    // ---------------- assertions ----------------
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_state == '0 && err_flags == '0));

    assert_no_false_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fault_mask == '0) |=> !err_any);

    assert_single_fault_seen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $countones(fault_mask) == 1) |=> (err_any && $countones(err_flags) == 1));

    assert_last_round_xor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && last_round && fault_mask == '0) |=>
            (out_state == $past(in_state ^ round_key)));

endmodule

// File: tb/aes_dec_ark_imc_chk_bench.sv
module aes_dec_ark_imc_chk_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         last_round = 1'b0;
    logic [127:0] in_state = '0;
    logic [127:0] round_key = '0;
    logic [127:0] fault_mask = '0;
    logic         out_valid;
    logic [127:0] out_state;
    logic [15:0]  err_flags;
    logic         err_any;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    aes_dec_ark_imc_chk u_aes_dec_ark_imc_chk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .last_round(last_round),
        .in_state(in_state), .round_key(round_key), .fault_mask(fault_mask),
        .out_valid(out_valid), .out_state(out_state), .err_flags(err_flags),
        .err_any(err_any)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= a;
            a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
        end
        return p;
    endfunction

    function automatic logic [127:0] ref_round(input logic [127:0] s, input logic [127:0] k,
                                               input logic last);
        logic [127:0] t, o;
        logic [7:0] coef [4];
        logic [7:0] acc;
        coef = '{8'h0E, 8'h0B, 8'h0D, 8'h09};
        t = s ^ k;
        if (last) return t;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                acc = 8'h00;
                for (int j = 0; j < 4; j++)
                    acc ^= gm(coef[(j - r + 4) % 4], t[(4*c + j)*8 +: 8]);
                o[(4*c + r)*8 +: 8] = acc;
            end
        end
        return o;
    endfunction

    // flags of a fault-free round are zero, so each mask bit toggles one flag
    function automatic logic [15:0] ref_flags(input logic [127:0] m);
        logic [15:0] f;
        f = '0;
        for (int k = 0; k < 128; k++)
            if (m[k]) f[4*((k/8)/4) + ((k%8)%4)] ^= 1'b1;
        return f;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one cycle, then compare at the next falling edge
    task automatic step(input logic v, input logic [127:0] s, input logic [127:0] k,
                        input logic last, input logic [127:0] m, input string req);
        logic [127:0] es;
        logic [15:0]  ef;
        in_valid = v; in_state = s; round_key = k; last_round = last; fault_mask = m;
        es = v ? (ref_round(s, k, last) ^ m) : '0;
        ef = v ? ref_flags(m) : '0;
        @(negedge clk);
        chk(out_valid == v, "R2", "out_valid", 128'(out_valid), 128'(v));
        chk(out_state == es, req, "out_state", out_state, es);
        chk(err_flags == ef, req, "err_flags", 128'(err_flags), 128'(ef));
        chk(err_any == (ef != 0), "R10", "err_any", 128'(err_any), 128'(ef != 0));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] s;
        @(negedge clk);
        in_valid = 1'b1; in_state = rnd128();
        @(negedge clk);
        @(negedge clk);
        // R1: outputs held at zero during reset even with valid input
        chk(out_valid == 0, "R1", "out_valid", 128'(out_valid), 0);
        chk(out_state == 0, "R1", "out_state", out_state, 0);
        chk(err_flags == 0 && err_any == 0, "R1", "flags", 128'({err_any, err_flags}), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: known inverse-mix columns, key zero
        s = '0;
        s[31:0]   = 32'hbca14d8e;
        s[63:32]  = 32'h9d58dc9f;
        s[95:64]  = 32'h01010101;
        s[127:96] = 32'h455313db;
        step(1'b1, s, '0, 1'b0, '0, "R4");
        chk(out_state[31:0] == 32'h455313db, "R3", "col0", 128'(out_state[31:0]), 128'(32'h455313db));
        chk(out_state[63:32] == 32'h5c220af2, "R3", "col1", 128'(out_state[63:32]), 128'(32'h5c220af2));
        chk(out_state[95:64] == 32'h01010101, "R4", "col2", 128'(out_state[95:64]), 128'(32'h01010101));

        // R4/R6: random normal rounds, back to back and with bubbles
        for (int i = 0; i < 40; i++) begin
            step(1'b1, rnd128(), rnd128(), 1'b0, '0, "R4");
            if (i % 7 == 3) step(1'b0, rnd128(), rnd128(), 1'b0, rnd128(), "R2");
        end
        // R5/R6: last round
        for (int i = 0; i < 30; i++)
            step(1'b1, rnd128(), rnd128(), 1'b1, '0, "R5");

        // R8/R9: single-bit fault sweep in both modes
        for (int k = 0; k < 128; k++) begin
            step(1'b1, rnd128(), rnd128(), 1'b0, 128'(1) << k, "R9");
            step(1'b1, rnd128(), rnd128(), 1'b1, 128'(1) << k, "R8");
        end

        // R11: cancelling pairs raise no flag
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 4; i++) begin
                logic [127:0] m;
                m = (128'(1) << (32*c + i)) | (128'(1) << (32*c + i + 4));
                step(1'b1, rnd128(), rnd128(), 1'b0, m, "R11");
                chk(err_any == 0, "R11", "nibble pair", 128'(err_any), 0);
                m = (128'(1) << (32*c + i)) | (128'(1) << (32*c + 16 + i));
                step(1'b1, rnd128(), rnd128(), 1'b1, m, "R11");
                chk(err_any == 0, "R11", "row pair", 128'(err_any), 0);
            end
        end

        // R7: random multi-bit masks
        for (int i = 0; i < 60; i++)
            step(1'b1, rnd128(), rnd128(), 1'(i % 2), rnd128(), "R7");

        step(1'b0, '0, '0, 1'b0, '0, "R2");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule